// File: doc/BRIEF.md
# Vector condition-test result packer

This block gathers one-bit condition-test outcomes, one per vector element, and packs them into 64-bit integer destination elements. A single-cycle start pulse loads the number of results to expect, a 2-bit packing code and a scalar/vector destination select. After that, one result arrives per strobe, each tagged with its element index. The packing code sets the density of each destination element: 1, 2, 4 or 8 results, each at the low end of the element. The density comes from the width code of the condition source, not from the width of the integer destination. When the destination is scalar, every result lands bitwise in a single register.

Each destination element is emitted once, as a write of a register offset and a 64-bit value. The write happens when the element's last slot fills, or after the final result, whichever comes first. Slots that were never filled and all bits above the packed group read as zero. A done pulse marks the end of the sequence. An index that breaks the ascending order raises a sticky error flag, and the result that carried it is dropped. The test outcomes themselves and the register file lie outside this block.

Top module: `ctest_packer`

## Requirements
- R1: After a synchronous active-low reset, wr_valid_o, done_o and error_o are low.
- R2: With pack code 00 (vector), result i is written to offset i at bit 0, and bits 63:1 are zero.
- R3: With pack code 01 (vector), result i goes to offset i/2 at bit (i mod 2) counted from the LSB, and bits 63:2 are zero.
- R4: With pack code 10 (vector), result i goes to offset i/4 at bit (i mod 4). With code 11, it goes to offset i/8 at bit (i mod 8). Bits above the group are zero in both cases.
- R5: With the scalar select high, result i is placed at bit i of one register. That register is written exactly once, at offset 0, when the sequence completes.
- R6: Each destination element is written once, in ascending offset order, one cycle after the accepted result that fills its last slot or that is the final result. The slots of a partial final group read as zero.
- R7: A count above 64 is treated as 64. A count of 0 produces a done pulse one cycle after start, with no write.
- R8: A result strobe whose index differs from the next expected index sets error_o and is neither counted nor written. error_o stays high until the next accepted start clears it.
- R9: done_o is a single-cycle pulse, issued once per sequence in the same cycle as the final write.
- R10: A start pulse during a running sequence is ignored. A result strobe while no sequence runs is ignored and causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a sequence (accepted when idle) |
| count_i | input | 7 | Number of results in the sequence |
| pack_code_i | input | 2 | Results per element: 00=1, 01=2, 10=4, 11=8 |
| scalar_i | input | 1 | 1: pack all results into one register |
| res_valid_i | input | 1 | Result strobe |
| res_bit_i | input | 1 | Condition-test result bit |
| res_idx_i | input | 6 | Element index of the result |
| wr_valid_o | output | 1 | Destination write strobe |
| wr_ofs_o | output | 6 | Destination register offset |
| wr_data_o | output | 64 | Destination register value |
| done_o | output | 1 | Sequence complete pulse |
| error_o | output | 1 | Sticky out-of-order index flag |

## Verification
The hardest situation to reach is an out-of-order index in the middle of a group, followed by the correct in-order resumption. The written values must then show that the dropped bit left no trace. Directed stimulus injects such a skip during a running sequence and checks both the flag and the later writes. Random sequences cover every packing code with counts that leave partial final groups. The 64-result ceiling is exercised by an over-long scalar count, and restarts are attempted while a sequence is still running.

// File: rtl/ctp_pkg.sv
// Package: shared types for the condition-test result packer.
// Assumes: the pack code is a log2 of the results placed per destination element.
package ctp_pkg;
    typedef enum logic [1:0] {
        PK_X1 = 2'b00,
        PK_X2 = 2'b01,
        PK_X4 = 2'b10,
        PK_X8 = 2'b11
    } pack_code_e;

    typedef struct packed {
        logic       scalar;
        pack_code_e code;
    } pack_cfg_t;
endpackage

// File: rtl/ctp_seq.sv
// Module: ctp_seq
// Sequences one packing run. It accepts a start pulse when idle, clamps the
// count, tracks the next expected element index, flags out-of-order strobes,
// and raises done after the final result.
// Assumes: results arrive in ascending index order starting at 0.
module ctp_seq #(
    parameter int MAX_CNT = 64,
    parameter int CNT_W   = 7,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             res_valid_i,
    input  logic [IDX_W-1:0] res_idx_i,
    output logic             load_o,
    output logic             accept_o,
    output logic             last_o,
    output logic             done_o,
    output logic             error_o
);
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] exp_q;
    logic [CNT_W-1:0] clamped;
    logic             bad;

    // Purpose: clamp the requested count and classify the incoming strobe.
    always_comb begin
        clamped  = (count_i > CNT_W'(MAX_CNT)) ? CNT_W'(MAX_CNT) : count_i;
        load_o   = start_i & ~busy_q;
        accept_o = busy_q & res_valid_i & (CNT_W'(res_idx_i) == exp_q);
        bad      = busy_q & res_valid_i & (CNT_W'(res_idx_i) != exp_q);
        last_o   = accept_o & (exp_q == cnt_q - 1'b1);
    end

    // Purpose: run state, expected index, done pulse and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            exp_q   <= '0;
            done_o  <= 1'b0;
            error_o <= 1'b0;
        end else if (load_o) begin
            busy_q  <= (clamped != '0);
            cnt_q   <= clamped;
            exp_q   <= '0;
            done_o  <= (clamped == '0);
            error_o <= 1'b0;
        end else begin
            done_o <= last_o;
            if (accept_o) exp_q <= exp_q + 1'b1;
            if (last_o) busy_q <= 1'b0;
            if (bad) error_o <= 1'b1;
        end
    end

    // R9: done never lasts two cycles
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10: nothing is accepted while idle
    a_r10_idle_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !accept_o);
    // R7: the loaded count never exceeds the ceiling
    a_r7_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_CNT));
    // R8: error persists until a start is accepted
    a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && !load_o) |=> error_o);
endmodule

// File: rtl/ctp_slot.sv
// Module: ctp_slot
// Maps an element index to a bit slot, a destination offset and a group-end
// flag. There is one variant per pack code, plus the scalar variant.
// Assumes: 8 <= DATA_W and MAX_CNT <= DATA_W, so a scalar slot always fits.
module ctp_slot #(
    parameter int IDX_W  = 6,
    parameter int SLOT_W = 6
) (
    input  logic             [IDX_W-1:0]  idx_i,
    input  ctp_pkg::pack_cfg_t            cfg_i,
    output logic             [SLOT_W-1:0] slot_o,
    output logic             [IDX_W-1:0]  ofs_o,
    output logic                          grp_end_o
);
    localparam int N_CODES = 4;

    logic [SLOT_W-1:0] slot_v [N_CODES];
    logic [IDX_W-1:0]  ofs_v  [N_CODES];
    logic              end_v  [N_CODES];

    for (genvar g = 0; g < N_CODES; g++) begin : g_code
        localparam int GRP = 1 << g;
        // Purpose: slot, offset and group end for 2**g results per element.
        always_comb begin
            slot_v[g] = SLOT_W'(idx_i & IDX_W'(GRP - 1));
            ofs_v[g]  = idx_i >> g;
            end_v[g]  = (slot_v[g] == SLOT_W'(GRP - 1));
        end
    end

    // Purpose: select the scalar mapping or the pack-code variant.
    always_comb begin
        if (cfg_i.scalar) begin
            slot_o    = SLOT_W'(idx_i);
            ofs_o     = '0;
            grp_end_o = 1'b0;
        end else begin
            slot_o    = slot_v[cfg_i.code];
            ofs_o     = ofs_v[cfg_i.code];
            grp_end_o = end_v[cfg_i.code];
        end
    end
endmodule

// File: rtl/ctp_accum.sv
// Module: ctp_accum
// Merges accepted result bits into the current destination element and emits
// it as a registered write when told to flush. It then restarts from zero.
// Assumes: clear_i and acc_en_i are never high together.
module ctp_accum #(
    parameter int DATA_W = 64,
    parameter int SLOT_W = 6,
    parameter int OFS_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              acc_en_i,
    input  logic              flush_i,
    input  logic              bit_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic              wr_valid_o,
    output logic [OFS_W-1:0]  wr_ofs_o,
    output logic [DATA_W-1:0] wr_data_o
);
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] merged;

    // Purpose: place the new bit into its slot on top of the partial value.
    always_comb merged = acc_q | (DATA_W'(bit_i) << slot_i);

    // Purpose: accumulate, flush to the write port, clear on a new run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            wr_valid_o <= 1'b0;
            wr_ofs_o   <= '0;
            wr_data_o  <= '0;
        end else begin
            wr_valid_o <= acc_en_i & flush_i;
            if (clear_i) begin
                acc_q <= '0;
            end else if (acc_en_i && flush_i) begin
                wr_data_o <= merged;
                wr_ofs_o  <= ofs_i;
                acc_q     <= '0;
            end else if (acc_en_i) begin
                acc_q <= merged;
            end
        end
    end

    // R6: every write is caused by an accepted result one cycle earlier
    a_r6_write_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> $past(acc_en_i));
    // R6: the partial value starts empty after each write
    a_r6_fresh_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (acc_q == '0));
endmodule

// File: rtl/ctest_packer.sv
// Module: ctest_packer (top)
// Packs per-element condition-test bits into 64-bit destination elements at
// a density of 1/2/4/8 per element, or all of them into one scalar register.
// Assumes: the caller presents results in ascending index order, one per strobe.
module ctest_packer #(
    parameter int DATA_W  = 64,
    parameter int MAX_CNT = 64,
    parameter int CNT_W   = $clog2(MAX_CNT + 1),
    parameter int IDX_W   = $clog2(MAX_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [1:0]        pack_code_i,
    input  logic              scalar_i,
    input  logic              res_valid_i,
    input  logic              res_bit_i,
    input  logic [IDX_W-1:0]  res_idx_i,
    output logic              wr_valid_o,
    output logic [IDX_W-1:0]  wr_ofs_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              done_o,
    output logic              error_o
);
    import ctp_pkg::*;

    localparam int SLOT_W = $clog2(DATA_W);

    pack_cfg_t         cfg_q;
    logic              load, accept, last, grp_end, flush;
    logic [SLOT_W-1:0] slot;
    logic [IDX_W-1:0]  ofs;

    ctp_seq #(.MAX_CNT(MAX_CNT), .CNT_W(CNT_W), .IDX_W(IDX_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
        .res_valid_i(res_valid_i), .res_idx_i(res_idx_i),
        .load_o(load), .accept_o(accept), .last_o(last),
        .done_o(done_o), .error_o(error_o)
    );

    // Purpose: hold the run's packing configuration from start to done.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else if (load) cfg_q <= '{scalar: scalar_i, code: pack_code_e'(pack_code_i)};
    end

    ctp_slot #(.IDX_W(IDX_W), .SLOT_W(SLOT_W)) slot_i (
        .idx_i(res_idx_i), .cfg_i(cfg_q),
        .slot_o(slot), .ofs_o(ofs), .grp_end_o(grp_end)
    );

    // Purpose: write out when a group fills or the run ends.
    always_comb flush = last | grp_end;

    ctp_accum #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .OFS_W(IDX_W)) acc_i (
        .clk(clk), .rst_n(rst_n), .clear_i(load), .acc_en_i(accept),
        .flush_i(flush), .bit_i(res_bit_i), .slot_i(slot), .ofs_i(ofs),
        .wr_valid_o(wr_valid_o), .wr_ofs_o(wr_ofs_o), .wr_data_o(wr_data_o)
    );

    // R2, R3, R4: bits above the packed group are zero
    a_r4_high_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !cfg_q.scalar) |-> ((wr_data_o >> (1 << cfg_q.code)) == '0));
    // R5: scalar runs always target offset 0
    a_r5_scalar_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && cfg_q.scalar) |-> (wr_ofs_o == '0));
    // R9: completion of a non-empty run coincides with its final write
    a_r9_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !$past(load)) |-> wr_valid_o);
endmodule

// File: tb/ctest_packer_tb_top.sv
module ctest_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  count_i = '0;
    logic [1:0]  pack_code_i = '0;
    logic        scalar_i = 1'b0;
    logic        res_valid_i = 1'b0;
    logic        res_bit_i = 1'b0;
    logic [5:0]  res_idx_i = '0;
    logic        wr_valid_o;
    logic [5:0]  wr_ofs_o;
    logic [63:0] wr_data_o;
    logic        done_o;
    logic        error_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [5:0]  wofs [64];
    logic [63:0] wdat [64];
    int nw = 0;
    int ndone = 0;
    int ndone_wr = 0;
    logic rb [64];

    ctest_packer dut_i (.*);

    always #4 clk = ~clk;

    // Record writes and completion pulses away from the active edge.
    always @(negedge clk) begin
        if (wr_valid_o && nw < 64) begin
            wofs[nw] = wr_ofs_o;
            wdat[nw] = wr_data_o;
            nw++;
        end
        if (done_o) begin
            ndone++;
            if (wr_valid_o) ndone_wr++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr_log();
        nw = 0; ndone = 0; ndone_wr = 0;
    endtask

    task automatic do_start(input int cnt, input int code, input bit sc);
        @(negedge clk);
        start_i = 1'b1; count_i = 7'(cnt); pack_code_i = 2'(code); scalar_i = sc;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send(input int idx, input bit b);
        @(negedge clk);
        res_valid_i = 1'b1; res_idx_i = 6'(idx); res_bit_i = b;
        @(negedge clk);
        res_valid_i = 1'b0;
    endtask

    task automatic compare(input int n, input int code, input bit sc, input string tag);
        logic [63:0] ex [64];
        int nexp;
        for (int k = 0; k < 64; k++) ex[k] = '0;
        for (int i = 0; i < n; i++) begin
            int o = sc ? 0 : (i >> code);
            int s = sc ? i : (i & ((1 << code) - 1));
            ex[o][s] = rb[i];
        end
        nexp = (n == 0) ? 0 : (sc ? 1 : ((n + (1 << code) - 1) >> code));
        chk(nw == nexp, "R6 write count", 64'(nw), 64'(nexp));
        for (int k = 0; k < nexp && k < nw; k++) begin
            chk(wofs[k] == 6'(k), "R6 offset order", 64'(wofs[k]), 64'(k));
            chk(wdat[k] == ex[k], tag, wdat[k], ex[k]);
        end
        chk(ndone == 1, "R9 one done pulse", 64'(ndone), 64'd1);
        if (n > 0) chk(ndone_wr == 1, "R9 done with final write", 64'(ndone_wr), 64'd1);
    endtask

    task automatic run_seq(input int cnt, input int code, input bit sc, input bit busy_start);
        int n = (cnt > 64) ? 64 : cnt;
        string tag;
        tag = sc ? "R5 scalar data" : (code == 0 ? "R2 data x1" : (code == 1 ? "R3 data x2" : "R4 data x4/x8"));
        clr_log();
        for (int i = 0; i < 64; i++) rb[i] = 1'($urandom);
        do_start(cnt, code, sc);
        for (int i = 0; i < n; i++) begin
            int gap = $urandom % 3;
            repeat (gap) @(negedge clk);
            if (busy_start && i == 1) do_start(5, 3, 1'b1);  // R10 start while running
            send(i, rb[i]);
        end
        repeat (3) @(negedge clk);
        compare(n, code, sc, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!wr_valid_o && !done_o && !error_o, "R1 reset outputs",
            {61'd0, wr_valid_o, done_o, error_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed partial groups for each code (R2 R3 R4 R6)
        run_seq(3, 0, 1'b0, 1'b0);
        run_seq(5, 1, 1'b0, 1'b0);
        run_seq(7, 2, 1'b0, 1'b0);
        run_seq(13, 3, 1'b0, 1'b0);
        run_seq(1, 3, 1'b0, 1'b0);
        // R5 scalar
        run_seq(37, 2, 1'b1, 1'b0);
        // R7 clamp: a count of 100 completes after 64 results
        run_seq(100, 0, 1'b1, 1'b0);
        // R7 zero count
        run_seq(0, 1, 1'b0, 1'b0);
        // R10 start during a run is ignored
        run_seq(8, 1, 1'b0, 1'b1);

        // R10 result strobe while idle
        clr_log();
        send(0, 1'b1);
        repeat (3) @(negedge clk);
        chk(nw == 0 && ndone == 0, "R10 idle strobe ignored", 64'(nw + ndone), 64'd0);

        // R8 out-of-order index
        clr_log();
        rb[0] = 1; rb[1] = 0; rb[2] = 1; rb[3] = 0;
        do_start(4, 0, 1'b0);
        send(0, 1'b1);
        chk(!error_o, "R8 no error in order", 64'(error_o), 64'd0);
        send(2, 1'b1);
        chk(error_o, "R8 error on skip", 64'(error_o), 64'd1);
        send(1, 1'b0);
        send(2, 1'b1);
        send(3, 1'b0);
        repeat (3) @(negedge clk);
        chk(error_o, "R8 error sticky", 64'(error_o), 64'd1);
        compare(4, 0, 1'b0, "R8 skipped bit dropped");
        clr_log();
        do_start(1, 0, 1'b0);
        chk(!error_o, "R8 cleared by start", 64'(error_o), 64'd0);
        rb[0] = 1;
        send(0, 1'b1);
        repeat (3) @(negedge clk);
        compare(1, 0, 1'b0, "R2 data x1");

        // Random sequences
        for (int t = 0; t < 40; t++) begin
            int cnt = 1 + ($urandom % 64);
            int code = $urandom % 4;
            bit sc = (($urandom % 4) == 0);
            run_seq(cnt, code, sc, 1'b0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule